// File: doc/BRIEF.md
# Interrupt Routing Register Window

This block holds the programmable state of a 24-input interrupt routing controller and makes it reachable from a narrow 32-bit register bus. The bus sees only two live offsets. One is a select register. The other is a data window. Software first writes an index into the select register. It then reads or writes the data window, which reaches the register chosen by that index. Behind the window sit a controller identification byte, a fixed version word, a reserved word and a table of 64-bit routing entries. Each routing entry is split into a low word and a high word.

The whole routing table is driven out flat to the dispatch logic downstream. A one-cycle `table_upd` strobe follows every write that lands in the table, and the dispatcher treats it as a request to re-scan its pending inputs against the new routing.

Top module: `irq_route_regs`

## Requirements
- R1: Only offsets 0x00 and 0x10 of the 8-bit bus offset are decoded. A write to offset 0x00 loads `bus_wdata[7:0]` into the select register, and a read of offset 0x00 returns the select value zero-extended. Offset 0x10 is the data window onto the register chosen by the select value.
- R2: A read of any other offset returns 0, and a write to any other offset changes no state.
- R3: Select index 0 is the controller ID. Reads return it in bits 31:24 with all other bits 0. A write stores `bus_wdata[31:24]` only.
- R4: Select index 1 is read-only. It reads as 0x11 in bits 7:0 and NUM_ENT-1 (23) in bits 23:16, with every other bit 0.
- R5: Select index 2 reads as 0. Writes through the window at index 1 or 2 change no state.
- R6: Routing entry n is at select index 0x10+2n for bits 31:0 and at 0x11+2n for bits 63:32. A window write replaces only that half. Entry n is driven on `route_table[64n+63:64n]`.
- R7: Select indices 3 to 0x0F, and indices from 0x10+2*NUM_ENT up to 0xFF, read as 0 through the window and ignore window writes.
- R8: While `rst_n` is low at a clock edge, the ID and select register clear to 0 and every entry becomes 0x0000_0000_0001_0000.
- R9: `table_upd` is high for exactly the one cycle that follows each clock edge at which a window write hit a routing entry. It is low in every other cycle, including after ID, select and ignored writes.
- R10: `bus_rdata` is combinational from the current offset, select value and register state. A value written at one edge is readable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Bus offset |
| bus_we | input | 1 | Write enable, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| route_table | output | NUM_ENT*64 | All routing entries, entry n at bits 64n+63:64n |
| table_upd | output | 1 | One-cycle request to re-scan after a table write |

## Verification
The hardest cases to reach are the edges of the index space: the high half of the last entry at 0x3F, the first index past it at 0x40, and the gap 0x03 to 0x0F. Each of these needs a select write before the window access. The bench therefore sweeps the select value through all 256 indices, reading the window at each one. It writes every entry half with distinct patterns, aims writes at out-of-range and read-only indices, and issues back-to-back table writes so that the strobe has to stay high for consecutive cycles.

// File: rtl/irq_route_pkg.sv
// Package irq_route_pkg
// Holds the constants and the decoded-target type shared by the routing
// register window and its decoder. It assumes an 8-bit select index and
// 32-bit bus words.
package irq_route_pkg;
    localparam int SEL_W   = 8;
    localparam int WORD_W  = 32;
    localparam int ENT_W   = 2 * WORD_W;
    localparam logic [7:0] VERSION = 8'h11;
    localparam logic [SEL_W-1:0] TAB_BASE = 8'h10;
    localparam logic [ENT_W-1:0] ENT_RESET = 64'h0000_0000_0001_0000;

    typedef enum logic [2:0] {
        TGT_ID,
        TGT_VER,
        TGT_RSV,
        TGT_ENT,
        TGT_NONE
    } win_tgt_e;
endpackage

// File: rtl/irq_route_decode.sv
// Module irq_route_decode
// Turns the select index into a window target. For a table index it also
// gives the entry number and the half. It assumes NUM_ENT entries at
// TAB_BASE, two indices each, with the even index holding the low half.
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_ENT = 24,
    localparam int IDX_W = $clog2(NUM_ENT)
) (
    input  logic [SEL_W-1:0] sel,
    output win_tgt_e         tgt,
    output logic [IDX_W-1:0] ent_idx,
    output logic             ent_hi
);
    localparam logic [SEL_W-2:0] ENT_LIM = (SEL_W-1)'(NUM_ENT);

    logic [SEL_W-1:0] off;

    // Offset of the select value from the start of the table.
    assign off     = sel - TAB_BASE;
    assign ent_idx = off[IDX_W:1];
    assign ent_hi  = off[0];

    // Classify the select value into one window target.
    always_comb begin
        if (sel >= TAB_BASE) begin
            tgt = (off[SEL_W-1:1] < ENT_LIM) ? TGT_ENT : TGT_NONE;
        end else begin
            case (sel)
                8'd0:    tgt = TGT_ID;
                8'd1:    tgt = TGT_VER;
                8'd2:    tgt = TGT_RSV;
                default: tgt = TGT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/irq_route_entry.sv
// Module irq_route_entry
// One 64-bit routing entry, written one half at a time. It assumes that
// wr_lo and wr_hi are never high together. Reset leaves only the mask bit set.
module irq_route_entry
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [ENT_W-1:0]  entry
);
    // Hold the entry and replace one half per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry <= ENT_RESET;
        end else if (wr_lo) begin
            entry[WORD_W-1:0] <= wdata;
        end else if (wr_hi) begin
            entry[ENT_W-1:WORD_W] <= wdata;
        end
    end
endmodule

// File: rtl/irq_route_regs.sv
// Module irq_route_regs
// Register window of the interrupt routing controller. A select register at
// offset 0x00 chooses what the window at offset 0x10 reaches: the ID, the
// version, a reserved word or one half of a routing entry. Reads are
// combinational. Writes act at the clock edge, and a table write raises
// table_upd for the next cycle. Reset is synchronous and active low.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_ENT = 24,
    localparam int IDX_W = $clog2(NUM_ENT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               bus_addr,
    input  logic                     bus_we,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    output logic [NUM_ENT*ENT_W-1:0] route_table,
    output logic                     table_upd
);
    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;
    localparam logic [WORD_W-1:0] VER_WORD = {8'h00, 8'(NUM_ENT - 1), 8'h00, VERSION};

    logic [SEL_W-1:0] sel_q;
    logic [7:0]       id_q;
    logic             upd_q;
    win_tgt_e         tgt;
    logic [IDX_W-1:0] ent_idx;
    logic             ent_hi;
    logic             hit_sel;
    logic             hit_win;
    logic             wr_win;
    logic             wr_ent;
    logic [ENT_W-1:0] ent_q [NUM_ENT];
    logic [ENT_W-1:0] ent_rd;

    assign hit_sel = (bus_addr == OFF_SEL);
    assign hit_win = (bus_addr == OFF_WIN);
    assign wr_win  = bus_we && hit_win;
    assign wr_ent  = wr_win && (tgt == TGT_ENT);

    irq_route_decode #(.NUM_ENT(NUM_ENT)) u_dec (
        .sel     (sel_q),
        .tgt     (tgt),
        .ent_idx (ent_idx),
        .ent_hi  (ent_hi)
    );

    // Select register, loaded from the low byte of a write at offset 0x00.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (bus_we && hit_sel) begin
            sel_q <= bus_wdata[SEL_W-1:0];
        end
    end

    // Controller ID, loaded from the top byte of a window write at index 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= '0;
        end else if (wr_win && (tgt == TGT_ID)) begin
            id_q <= bus_wdata[31:24];
        end
    end

    // Re-scan strobe, high for the cycle after a table write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_q <= 1'b0;
        end else begin
            upd_q <= wr_ent;
        end
    end

    assign table_upd = upd_q;

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        logic hit_i;
        assign hit_i = wr_ent && (ent_idx == IDX_W'(i));

        irq_route_entry u_ent (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_lo (hit_i && !ent_hi),
            .wr_hi (hit_i && ent_hi),
            .wdata (bus_wdata),
            .entry (ent_q[i])
        );

        assign route_table[i*ENT_W +: ENT_W] = ent_q[i];
    end

    // Select the addressed entry for a window read.
    always_comb begin
        ent_rd = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (ent_idx == IDX_W'(i)) begin
                ent_rd = ent_q[i];
            end
        end
    end

    // Build the read word from the offset and the current select.
    always_comb begin
        bus_rdata = '0;
        if (hit_sel) begin
            bus_rdata = {{(WORD_W-SEL_W){1'b0}}, sel_q};
        end else if (hit_win) begin
            case (tgt)
                TGT_ID:  bus_rdata = {id_q, 24'h0};
                TGT_VER: bus_rdata = VER_WORD;
                TGT_ENT: bus_rdata = ent_hi ? ent_rd[ENT_W-1:WORD_W] : ent_rd[WORD_W-1:0];
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_route_chk.sv
// Module irq_route_chk
// Assertion checker for irq_route_regs. The bind below attaches it. It sees
// the ports and the select register, and assumes a synchronous active-low reset.
module irq_route_chk #(
    parameter int NUM_ENT = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [7:0]             bus_addr,
    input logic                   bus_we,
    input logic [31:0]            bus_rdata,
    input logic [NUM_ENT*64-1:0]  route_table,
    input logic                   table_upd,
    input logic [7:0]             sel_q
);
    localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENT - 1), 8'h00, 8'h11};

    logic in_tab;
    logic tab_wr;

    assign in_tab = (int'(sel_q) >= 16) && (int'(sel_q) < 16 + 2 * NUM_ENT);
    assign tab_wr = bus_we && (bus_addr == 8'h10) && in_tab;

    AST_UPD_AFTER_TABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tab_wr |=> table_upd); // R9
    AST_UPD_QUIET_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        !tab_wr |=> !table_upd); // R9
    AST_VERSION_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h10 && sel_q == 8'd1) |-> bus_rdata == VER_WORD); // R4
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h10 && sel_q == 8'd2) |-> bus_rdata == 32'h0); // R5
    AST_TABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !tab_wr |=> $stable(route_table)); // R7
    AST_DEAD_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != 8'h00 && bus_addr != 8'h10) |-> bus_rdata == 32'h0); // R2
endmodule

bind irq_route_regs irq_route_chk #(.NUM_ENT(NUM_ENT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_rdata   (bus_rdata),
    .route_table (route_table),
    .table_upd   (table_upd),
    .sel_q       (sel_q)
);

// File: tb/sim_irq_route_regs.sv
// Bench for irq_route_regs. A behavioural model is updated at every clock
// edge. Outputs are compared with it at the falling edge and again after the
// inputs change.
module sim_irq_route_regs;
    localparam int N = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [N*64-1:0]   route_table;
    logic              table_upd;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic [7:0]  m_sel;
    logic [7:0]  m_id;
    logic        m_upd;
    logic [31:0] m_lo [N];
    logic [31:0] m_hi [N];

    always #10 clk = ~clk;

    irq_route_regs #(.NUM_ENT(N)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .route_table(route_table), .table_upd(table_upd)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        m_sel = '0; m_id = '0; m_upd = 1'b0;
        for (int i = 0; i < N; i++) begin
            m_lo[i] = 32'h0001_0000; m_hi[i] = 32'h0;
        end
    endtask

    function automatic bit m_in_tab();
        return (int'(m_sel) >= 16) && (int'(m_sel) < 16 + 2 * N);
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        int k;
        if (a == 8'h00) return {24'h0, m_sel};
        if (a != 8'h10) return 32'h0;
        if (m_sel == 8'd0) return {m_id, 24'h0};
        if (m_sel == 8'd1) return {8'h00, 8'(N - 1), 8'h00, 8'h11};
        if (!m_in_tab()) return 32'h0;
        k = (int'(m_sel) - 16) / 2;
        return m_sel[0] ? m_hi[k] : m_lo[k];
    endfunction

    task automatic m_write(logic [7:0] a, logic we, logic [31:0] d);
        int k;
        m_upd = we && (a == 8'h10) && m_in_tab();
        if (!we) return;
        if (a == 8'h00) m_sel = d[7:0];
        else if (a == 8'h10) begin
            if (m_sel == 8'd0) m_id = d[31:24];
            else if (m_in_tab()) begin
                k = (int'(m_sel) - 16) / 2;
                if (m_sel[0]) m_hi[k] = d; else m_lo[k] = d;
            end
        end
    endtask

    // Compare the strobe and the whole table with the model.
    task automatic chk_state(string tag);
        bit ok = 1;
        int bad = 0;
        chk("R9 table_upd", 64'(table_upd), 64'(m_upd));
        for (int i = N - 1; i >= 0; i--) begin
            if (route_table[i*64 +: 64] !== {m_hi[i], m_lo[i]}) begin
                ok = 0; bad = i;
            end
        end
        chk({tag, " R6 route_table"}, route_table[bad*64 +: 64],
            ok ? route_table[bad*64 +: 64] : {m_hi[bad], m_lo[bad]});
    endtask

    // One bus cycle: check state, drive, check read, take the edge.
    task automatic op(string tag, logic [7:0] a, logic we, logic [31:0] d);
        @(negedge clk);
        chk_state(tag);
        bus_addr = a; bus_we = we; bus_wdata = d;
        #1;
        chk({tag, " R10 read"}, 64'(bus_rdata), 64'(m_read(a)));
        @(posedge clk);
        m_write(a, we, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state of select, ID and table
        op("R8", 8'h10, 0, 0);
        op("R8", 8'h00, 0, 0);
        op("R1", 8'h00, 1, 32'hFFFF_FF11);
        op("R8", 8'h10, 0, 0);
        op("R1", 8'h00, 1, 32'h0000_0001);
        op("R4", 8'h10, 0, 0);
        op("R4", 8'h10, 1, 32'hFFFF_FFFF);
        op("R4", 8'h10, 0, 0);
        // R3: ID byte
        op("R3", 8'h00, 1, 32'h0);
        op("R3", 8'h10, 1, 32'hA5C3_7E19);
        op("R3", 8'h10, 0, 0);
        op("R5", 8'h00, 1, 32'h2);
        op("R5", 8'h10, 1, 32'hDEAD_BEEF);
        op("R5", 8'h10, 0, 0);
        // R6: every half of every entry, back to back
        for (int k = 0; k < 2 * N; k++) begin
            op("R6", 8'h00, 1, 32'(16 + k));
            op("R6", 8'h10, 1, 32'h9E37_79B9 * 32'(k + 1));
            op("R6", 8'h10, 1, 32'h7F4A_7C15 ^ 32'(k * 257));
        end
        op("R6", 8'h00, 1, 32'h15);
        op("R6", 8'h10, 1, 32'h0BAD_F00D);
        // R7: beyond the table and in the gap
        op("R7", 8'h00, 1, 32'h40);
        op("R7", 8'h10, 1, 32'h1234_5678);
        op("R7", 8'h00, 1, 32'h07);
        op("R7", 8'h10, 1, 32'h8765_4321);
        op("R7", 8'h00, 1, 32'hFF);
        op("R7", 8'h10, 1, 32'h1111_1111);
        // R2: dead offsets
        op("R2", 8'h04, 1, 32'h0000_0003);
        op("R2", 8'h20, 1, 32'hCAFE_0000);
        op("R2", 8'hF0, 1, 32'h1);
        op("R2", 8'h00, 0, 0);
        // R7 and R10: sweep every select index and read the window
        for (int s = 0; s < 256; s++) begin
            op("R7", 8'h00, 1, 32'(s));
            op("R7", 8'h10, 0, 0);
        end
        // R9: mid-cycle reset, then the state after it
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        m_reset();
        @(negedge clk);
        rst_n = 1'b1;
        op("R8", 8'h00, 0, 0);
        op("R8", 8'h10, 0, 0);
        op("R9", 8'h00, 0, 0);
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule